// File: doc/BRIEF.md
# Selectable-Source Timestamp Counter with Clock-Output Divider

This block keeps a 33-bit timestamp that advances at a nominal 90 kHz, as used for aligning audio and video presentation times. It runs entirely in the master clock domain. Each advance comes from one of two tick sources, chosen by one control input. The first is an internal prescaler that divides the 27 MHz master clock by 300. The second is a rising edge on an external 90 kHz clock pin, brought into the master clock domain through a synchronizer.

Software can preset the counter through a parallel load port. It reads the counter through a snapshot register that captures all 33 bits in a single cycle, so a read done in several words cannot mix two counter values.

The block also makes a clock output. A programmable divide-by-Q stage is followed by a toggle flop, which gives a 50% duty square wave with period 2·Q master cycles. A new Q is adopted only at the divider's terminal count.

Top module: `stamp_timer`

## Requirements
- R1: While `rst_ni` is low, `count_o`, `snap_o` and `clk_o` are zero. The prescaler, the synchronizer and the divider counter are also cleared.
- R2: When `load_i` is high at a clock edge, `count_o` takes `load_val_i` at that edge. This holds even if a tick occurs in the same cycle.
- R3: Each tick without a load raises `count_o` by exactly one. The value 0x1_FFFF_FFFF wraps to zero. Without a tick or a load, `count_o` holds its value.
- R4: With `src_int_i` = 1, ticks come from a prescaler that runs freely from reset whatever the source selection. It issues one tick every 300 clock cycles. The first tick advances the counter at the 300th rising clock edge after reset is released.
- R5: With `src_int_i` = 0, each 0-to-1 transition of `ext_tick_i` produces exactly one tick. Levels and falling transitions produce none. Take an input that is first high at rising clock edge k. The count changes at edge k+2 and is visible after it, three edges after the input is presented.
- R6: The source that is not selected has no effect. Edges on `ext_tick_i` do not move the count while `src_int_i` = 1, and prescaler ticks do not move it while `src_int_i` = 0.
- R7: When `snap_i` is high at a clock edge, `snap_o` takes the value `count_o` had just before that edge. Otherwise `snap_o` holds.
- R8: The divisor is Q = `q_i` + 1, so codes 0 to 1023 map to Q = 1 to 1024. Once running, `clk_o` toggles every Q cycles, giving exactly Q cycles high and Q cycles low. Its frequency therefore ranges from clk/2 down to clk/2048.
- R9: A change of `q_i` is adopted only when the divider reaches its terminal count. The reset divisor is Q = 1, so the first toggle of `clk_o` comes at the first edge after reset. No half period is ever shorter than the older or the newer Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (27 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_int_i | input | 1 | Tick source: 1 = internal divide-by-300, 0 = external pin |
| ext_tick_i | input | 1 | Asynchronous external 90 kHz clock |
| load_i | input | 1 | Load strobe for the counter |
| load_val_i | input | 33 | Value loaded into the counter |
| snap_i | input | 1 | Capture strobe for the snapshot register |
| q_i | input | 10 | Divisor code, Q = q_i + 1 |
| count_o | output | 33 | Live counter value |
| snap_o | output | 33 | Captured counter value |
| clk_o | output | 1 | Divided clock output, 50% duty |

## Verification
The counter is driven in internal mode with the external pin toggling freely. This separates a correct source mux from one that sums or swaps the sources. In external mode, sparse and dense pin edges with long high levels show whether the design counts edges or levels, and whether it has the three-edge latency. Directed cases place a load in the same cycle as a tick and let all ones wrap to zero. Random divisor codes are changed in the middle of a half period, which exposes a divider that takes the new Q early and produces a short pulse.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int unsigned CNT_W    = 33;
  localparam int unsigned PRESCALE = 300;
  localparam int unsigned Q_W      = 10;
  localparam int unsigned SYNC_N   = 2;
endpackage

// File: rtl/stamp_prescale.sv
module stamp_prescale #(
  parameter int unsigned DIV = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/stamp_sync_edge.sv
module stamp_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= async_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/stamp_count.sv
module stamp_count #(
  parameter int unsigned W = 33
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         snap_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] snap_o
);
  logic [W-1:0] cnt_q, snap_q;

  // load wins over tick; all-ones wraps naturally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // whole word captured in one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (snap_i) snap_q <= cnt_q;
  end

  assign count_o = cnt_q;
  assign snap_o  = snap_q;
endmodule

// File: rtl/stamp_clkdiv.sv
module stamp_clkdiv #(
  parameter int unsigned QW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [QW-1:0] q_i,
  output logic          clk_o,
  output logic          term_o,
  output logic [QW-1:0] q_act_o
);
  logic [QW-1:0] dcnt_q, qcur_q;
  logic          tog_q;

  assign term_o = (dcnt_q == qcur_q);

  // divisor is only swapped at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      qcur_q <= '0;
      tog_q  <= 1'b0;
    end else if (term_o) begin
      dcnt_q <= '0;
      qcur_q <= q_i;
      tog_q  <= ~tog_q;
    end else begin
      dcnt_q <= dcnt_q + 1'b1;
    end
  end

  assign clk_o   = tog_q;
  assign q_act_o = qcur_q;
endmodule

// File: rtl/stamp_timer.sv
module stamp_timer
  import stamp_pkg::*;
#(
  parameter int unsigned CW  = CNT_W,
  parameter int unsigned PRE = PRESCALE,
  parameter int unsigned QW  = Q_W,
  parameter int unsigned SN  = SYNC_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          src_int_i,
  input  logic          ext_tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          snap_i,
  input  logic [QW-1:0] q_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] snap_o,
  output logic          clk_o
);
  logic          pre_tick_w;
  logic          ext_rise_w;
  logic          tick_w;
  logic          div_term_w;
  logic [QW-1:0] q_act_w;

  stamp_prescale #(.DIV(PRE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (pre_tick_w)
  );

  stamp_sync_edge #(.STAGES(SN)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_tick_i),
    .rise_o  (ext_rise_w)
  );

  assign tick_w = src_int_i ? pre_tick_w : ext_rise_w;

  stamp_count #(.W(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .snap_i     (snap_i),
    .count_o    (count_o),
    .snap_o     (snap_o)
  );

  stamp_clkdiv #(.QW(QW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .q_i     (q_i),
    .clk_o   (clk_o),
    .term_o  (div_term_w),
    .q_act_o (q_act_w)
  );
endmodule

// File: rtl/stamp_timer_chk.sv
module stamp_timer_chk #(
  parameter int unsigned CW = 33,
  parameter int unsigned QW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          src_int_i,
  input logic          load_i,
  input logic [CW-1:0] load_val_i,
  input logic          snap_i,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] snap_o,
  input logic          clk_o,
  input logic          pre_tick_w,
  input logic          ext_rise_w,
  input logic          div_term_w,
  input logic [QW-1:0] q_act_w
);
  // R2
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i));

  // R3
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

  // R6
  int_src_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_int_i && !load_i && !pre_tick_w) |=> $stable(count_o));

  // R6
  ext_src_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_int_i && !load_i && !ext_rise_w) |=> $stable(count_o));

  // R7
  snap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> snap_o == $past(count_o));

  // R7
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_o));

  // R8
  clk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_term_w |=> $stable(clk_o));

  // R9
  q_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_term_w |=> $stable(q_act_w));
endmodule

bind stamp_timer stamp_timer_chk #(.CW(CW), .QW(QW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_int_i  (src_int_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .snap_i     (snap_i),
  .count_o    (count_o),
  .snap_o     (snap_o),
  .clk_o      (clk_o),
  .pre_tick_w (pre_tick_w),
  .ext_rise_w (ext_rise_w),
  .div_term_w (div_term_w),
  .q_act_w    (q_act_w)
);

// File: tb/tb_stamp_timer.sv
`timescale 1ns/1ps
module tb_stamp_timer;
  localparam int CW = 33;
  localparam int QW = 10;
  localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src_int = 1'b1;
  logic          ext = 1'b0;
  logic          load = 1'b0;
  logic [CW-1:0] load_val = '0;
  logic          snap = 1'b0;
  logic [QW-1:0] q = '0;
  logic [CW-1:0] count, snapv;
  logic          clko;

  int unsigned n_vec = 0, n_bad = 0;
  bit          done = 0;
  string       phase = "R1";

  always #2.5 clk = ~clk;

  stamp_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .src_int_i(src_int), .ext_tick_i(ext),
    .load_i(load), .load_val_i(load_val), .snap_i(snap), .q_i(q),
    .count_o(count), .snap_o(snapv), .clk_o(clko)
  );

  // reference built from the requirement text
  int            m_pre;
  logic          m_s1, m_s2, m_s3;
  logic [CW-1:0] m_cnt, m_snap;
  int            m_dcnt, m_qcur;
  logic          m_clk;

  function automatic logic m_tick(input logic sel, input int pre, input logic s2, input logic s3);
    return sel ? (pre == 299) : (s2 & ~s3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
      m_cnt <= '0; m_snap <= '0; m_dcnt <= 0; m_qcur <= 0; m_clk <= 0;
    end else begin
      m_pre <= (m_pre == 299) ? 0 : m_pre + 1;
      m_s1 <= ext; m_s2 <= m_s1; m_s3 <= m_s2;
      if (load) m_cnt <= load_val;
      else if (m_tick(src_int, m_pre, m_s2, m_s3)) m_cnt <= m_cnt + 1'b1;
      if (snap) m_snap <= m_cnt;
      if (m_dcnt == m_qcur) begin
        m_dcnt <= 0; m_qcur <= int'(q); m_clk <= ~m_clk;
      end else m_dcnt <= m_dcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare at the falling edge, then leave inputs to caller
  task automatic step();
    @(negedge clk);
    chk({phase, " count"}, 64'(count), 64'(m_cnt));
    chk("R7 snapshot",    64'(snapv), 64'(m_snap));
    chk("R8 clk_o",       64'(clko),  64'(m_clk));
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [CW-1:0] base;
    int hi_len;
    void'($urandom(32'h5a17));
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 count", 64'(count), 0);
    chk("R1 snap",  64'(snapv), 0);
    chk("R1 clk_o", 64'(clko),  0);
    rst_n = 1'b1;

    // R4 first tick lands on edge 300
    phase = "R4";
    q = 10'd3;
    steps(299);
    chk("R4 before 300th edge", 64'(count), 0);
    step();
    chk("R4 at 300th edge", 64'(count), 1);

    // R6 ext pin ignored in internal mode: 300-cycle window adds exactly 1
    phase = "R6";
    base = count;
    for (int i = 0; i < 300; i++) begin ext = ~ext; step(); end
    chk("R6 ext ignored when internal", 64'(count - base), 1);
    ext = 1'b0; steps(4);

    // R5 external edge latency of three edges
    phase = "R5";
    src_int = 1'b0;
    steps(4);
    base = count;
    ext = 1'b1;
    steps(2);
    chk("R5 no change after 2 edges", 64'(count), 64'(base));
    step();
    chk("R5 change after 3 edges", 64'(count), 64'(base + 1'b1));
    steps(20);
    chk("R5 high level counts once", 64'(count), 64'(base + 1'b1));
    ext = 1'b0; steps(5);
    chk("R5 falling edge not counted", 64'(count), 64'(base + 1'b1));

    // R6 prescaler ignored in external mode
    phase = "R6";
    base = count;
    steps(700);
    chk("R6 prescaler ignored when external", 64'(count), 64'(base));

    // R3 wrap from all ones
    phase = "R3";
    load = 1'b1; load_val = ALL1; step(); load = 1'b0;
    chk("R2 load all ones", 64'(count), 64'(ALL1));
    ext = 1'b1; steps(3);
    chk("R3 wrap to zero", 64'(count), 0);
    ext = 1'b0; steps(4);

    // R2 load in the same cycle as a tick
    phase = "R2";
    ext = 1'b1; step();
    load_val = 33'h1_2345_6789; step();
    load = 1'b1; step(); load = 1'b0;
    chk("R2 load beats tick", 64'(count), 64'h1_2345_6789);
    step();
    chk("R2 no late tick", 64'(count), 64'h1_2345_6789);
    ext = 1'b0; steps(3);

    // R7 snapshot capture and hold
    snap = 1'b1; base = count; step(); snap = 1'b0;
    chk("R7 captured", 64'(snapv), 64'(base));
    ext = 1'b1; steps(4); ext = 1'b0; steps(3);
    chk("R7 holds while counting", 64'(snapv), 64'(base));

    // R8 half period equals Q; R9 change adopted at terminal
    phase = "R8";
    q = 10'd4;
    while (clko !== 1'b0) step();
    while (clko !== 1'b1) step();
    while (clko !== 1'b0) step();
    while (clko !== 1'b1) step();
    hi_len = 0;
    while (clko === 1'b1) begin hi_len++; step(); end
    chk("R8 high time Q=5", 64'(hi_len), 5);
    phase = "R9";
    q = 10'd0;
    hi_len = 1;
    step();
    while (clko === 1'b0) begin hi_len++; step(); end
    chk("R9 old Q kept for current half", 64'(hi_len), 5);
    step();
    chk("R8 Q=1 toggles each cycle", 64'(clko), 0);

    // random mix against the reference
    phase = "R3";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 999) == 0) src_int = ~src_int;
      ext  = ($urandom_range(0, 3) == 0) ? ~ext : ext;
      load = ($urandom_range(0, 199) == 0);
      load_val = ($urandom_range(0, 1) == 0) ? (ALL1 - CW'($urandom_range(0, 3)))
                                             : {1'($urandom), $urandom};
      snap = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 299) == 0) q = QW'($urandom_range(0, 40));
      step();
    end
    load = 1'b0; snap = 1'b0;
    steps(10);
    finish_run();
  end
endmodule